// File: doc/BRIEF.md
# Frame-Synchronized Register Shadow Unit

This block sits between a sensor's control register bank and its readout timing generator and decides the moment at which each newly written register value becomes visible to the timing logic. Every field has a shadow copy and an active copy. When a field is written, only the shadow changes. The active copy is loaded later, according to the group the field belongs to. There are four groups: geometry fields, brightness fields, one shutter-width field, and plain fields that bypass shadowing.

Geometry and brightness fields are committed at the next frame start. The shutter width is committed after two frame starts, so an exposure that is already under way never sees a half-applied value. Brightness fields can be frozen by a hold input and are then released together. A restart request commits what is pending at once. In snapshot operation, values written between the end of a frame and the next trigger are applied immediately. Writes to geometry fields in continuous operation raise a bubble flag for one frame, which tells the timing generator to insert an extra vertical blank.

Top module: `fsr_shadow_top`

## Requirements
- R1: After reset, every active field value is zero and `bubble` is low.
- R2: A write to a plain field (addresses 12 and 13 with the default parameters) appears on `imm_active` in the cycle after the write. A write to an address of 14 or above changes no output.
- R3: A write to a geometry field (addresses 0 to 6) or a brightness field (addresses 7 to 10) leaves `geo_active` and `brt_active` unchanged until the next `frame_start` pulse. The new value appears in the cycle after that pulse.
- R4: A write to the shutter-width field (address 11) stays invisible across the first `frame_start` pulse after the write. It appears in the cycle after the second pulse.
- R5: While `sync_hold` is high, `brt_active` does not change. A brightness value written during the hold is committed at the first `frame_start` after `sync_hold` falls, not when it falls. Geometry fields are not affected by the hold.
- R6: A `restart` pulse commits pending geometry values and the most recently written shutter-width value in the cycle after the pulse. Brightness values held by `sync_hold` remain pending.
- R7: With `snapshot_mode` high, a write made after `frame_valid` falls and before the next `trigger` appears on the active output in the cycle after the write.
- R8: With `snapshot_mode` high, if `trigger` arrives while `frame_valid` is high, writes made after `frame_valid` falls follow the frame-start rule of R3.
- R9: In continuous mode (`snapshot_mode` low), a write to any geometry field raises `bubble` from the `frame_start` after the write until the following `frame_start`, even when the value is unchanged. `bubble` only rises on a frame start. Shutter-width and brightness writes never raise it.
- R10: No bubble is raised by geometry writes while `snapshot_mode` is high. A `restart` pulse clears `bubble` and discards a pending bubble.
- R11: When a field is written several times before its commit point, the last value written is the one committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Field address of the write |
| wr_data | input | 16 | Write data |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| frame_valid | input | 1 | High during the active part of a frame |
| trigger | input | 1 | Snapshot trigger pulse |
| snapshot_mode | input | 1 | High selects snapshot operation, low selects continuous |
| sync_hold | input | 1 | Freezes brightness commits while high |
| restart | input | 1 | One-cycle restart request |
| geo_active | output | 112 | Active geometry fields, field i at bits [16i+15:16i] |
| brt_active | output | 64 | Active brightness fields, field i at bits [16i+15:16i] |
| shutter_active | output | 16 | Active shutter-width value |
| imm_active | output | 32 | Active plain fields, field i at bits [16i+15:16i] |
| bubble | output | 1 | One-frame request for an extra vertical blank |

## Verification
The tests write the same field groups under different conditions and compare the results. One pattern writes during the active frame with no mode bits set. Others add the hold bit, a restart, or snapshot operation. The different outcomes show that each group keeps its own commit latency of zero, one or two frame starts. Snapshot writes are made both before and after a trigger, and a separate pattern places the trigger inside the frame. Together these separate the immediate window from the frame-start path. Bubble checks cover geometry writes in both modes, a shutter-only write, and a restart. They show that only continuous-mode geometry writes lead to exactly one flagged frame.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [1:0] {
        KIND_FRAME   = 2'd0,
        KIND_HOLD    = 2'd1,
        KIND_SHUTTER = 2'd2,
        KIND_IMM     = 2'd3
    } fsr_kind_e;

    typedef struct packed {
        logic fv;
        logic trig_in_fv;
        logic window;
        logic bub_pend;
        logic bubble;
    } ctl_state_t;

endpackage

// File: rtl/fsr_decode.sv
module fsr_decode #(
    parameter int AW    = 5,
    parameter int NSLOT = 14
) (
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    output logic [NSLOT-1:0] sel
);
    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            sel[i] = wr_en && (wr_addr == AW'(i));
        end
    end
endmodule

// File: rtl/fsr_slot.sv
module fsr_slot #(
    parameter int                DW   = 16,
    parameter fsr_pkg::fsr_kind_e KIND = fsr_pkg::KIND_FRAME
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          frame_start,
    input  logic          restart,
    input  logic          direct,
    input  logic          hold,
    output logic [DW-1:0] active
);
    import fsr_pkg::*;

    localparam bit TWO_STAGE = (KIND == KIND_SHUTTER);
    localparam bit HOLDABLE  = (KIND == KIND_HOLD);
    localparam bit BYPASS    = (KIND == KIND_IMM);

    typedef struct packed {
        logic [DW-1:0] st1;
        logic          p1;
        logic [DW-1:0] st2;
        logic          p2;
        logic [DW-1:0] act;
    } slot_t;

    slot_t s_d, s_q;
    logic  held;

    assign held = HOLDABLE && hold;

    always_comb begin
        s_d = s_q;
        if (BYPASS) begin
            if (wr) s_d.act = wdata;
        end else begin
            // commit points use the state from before this cycle's write
            if (restart) begin
                if (TWO_STAGE) begin
                    if (s_q.p1)      s_d.act = s_q.st1;
                    else if (s_q.p2) s_d.act = s_q.st2;
                    s_d.p1 = 1'b0;
                    s_d.p2 = 1'b0;
                end else if (s_q.p1 && !held) begin
                    s_d.act = s_q.st1;
                    s_d.p1  = 1'b0;
                end
            end else if (frame_start) begin
                if (TWO_STAGE) begin
                    if (s_q.p2) begin
                        s_d.act = s_q.st2;
                        s_d.p2  = 1'b0;
                    end
                    if (s_q.p1) begin
                        s_d.st2 = s_q.st1;
                        s_d.p2  = 1'b1;
                        s_d.p1  = 1'b0;
                    end
                end else if (s_q.p1 && !held) begin
                    s_d.act = s_q.st1;
                    s_d.p1  = 1'b0;
                end
            end
            if (wr) begin
                if (direct && !held) begin
                    s_d.act = wdata;
                    s_d.p1  = 1'b0;
                    s_d.p2  = 1'b0;
                end else begin
                    s_d.st1 = wdata;
                    s_d.p1  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active = s_q.act;
endmodule

// File: rtl/fsr_frame_ctl.sv
module fsr_frame_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic frame_valid,
    input  logic trigger,
    input  logic snapshot_mode,
    input  logic restart,
    input  logic geo_wr,
    output logic direct,
    output logic bubble
);
    import fsr_pkg::*;

    ctl_state_t c_d, c_q;
    logic       fv_fall;

    assign fv_fall = c_q.fv && !frame_valid;

    always_comb begin
        c_d    = c_q;
        c_d.fv = frame_valid;
        // snapshot write window: opens at end of frame unless already triggered
        if (!snapshot_mode) begin
            c_d.window     = 1'b0;
            c_d.trig_in_fv = 1'b0;
        end else begin
            if (fv_fall) begin
                c_d.window     = !c_q.trig_in_fv;
                c_d.trig_in_fv = 1'b0;
            end
            if (trigger) begin
                c_d.window = 1'b0;
                if (frame_valid) c_d.trig_in_fv = 1'b1;
            end
        end
        // bubble bookkeeping
        if (restart) begin
            c_d.bub_pend = 1'b0;
            c_d.bubble   = 1'b0;
        end else if (frame_start) begin
            c_d.bubble   = c_q.bub_pend;
            c_d.bub_pend = 1'b0;
        end
        if (geo_wr && !snapshot_mode) c_d.bub_pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign direct = c_q.window && snapshot_mode;
    assign bubble = c_q.bubble;
endmodule

// File: rtl/fsr_shadow_top.sv
module fsr_shadow_top #(
    parameter int DW      = 16,
    parameter int AW      = 5,
    parameter int NUM_GEO = 7,
    parameter int NUM_BRT = 4,
    parameter int NUM_IMM = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [DW-1:0]         wr_data,
    input  logic                  frame_start,
    input  logic                  frame_valid,
    input  logic                  trigger,
    input  logic                  snapshot_mode,
    input  logic                  sync_hold,
    input  logic                  restart,
    output logic [NUM_GEO*DW-1:0] geo_active,
    output logic [NUM_BRT*DW-1:0] brt_active,
    output logic [DW-1:0]         shutter_active,
    output logic [NUM_IMM*DW-1:0] imm_active,
    output logic                  bubble
);
    import fsr_pkg::*;

    localparam int BRT_BASE = NUM_GEO;
    localparam int SHW_ADDR = NUM_GEO + NUM_BRT;
    localparam int IMM_BASE = SHW_ADDR + 1;
    localparam int NSLOT    = IMM_BASE + NUM_IMM;

    logic [NSLOT-1:0] sel;
    logic [DW-1:0]    slot_act [NSLOT];
    logic             geo_wr;
    logic             direct;

    fsr_decode #(.AW(AW), .NSLOT(NSLOT)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .sel     (sel)
    );

    assign geo_wr = |sel[NUM_GEO-1:0];

    fsr_frame_ctl u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start   (frame_start),
        .frame_valid   (frame_valid),
        .trigger       (trigger),
        .snapshot_mode (snapshot_mode),
        .restart       (restart),
        .geo_wr        (geo_wr),
        .direct        (direct),
        .bubble        (bubble)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam fsr_kind_e K = (g < BRT_BASE) ? KIND_FRAME :
                                  (g < SHW_ADDR) ? KIND_HOLD  :
                                  (g == SHW_ADDR) ? KIND_SHUTTER : KIND_IMM;
        fsr_slot #(.DW(DW), .KIND(K)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr          (sel[g]),
            .wdata       (wr_data),
            .frame_start (frame_start),
            .restart     (restart),
            .direct      (direct),
            .hold        (sync_hold),
            .active      (slot_act[g])
        );
    end

    for (genvar i = 0; i < NUM_GEO; i++) begin : g_geo_out
        assign geo_active[i*DW +: DW] = slot_act[i];
    end
    for (genvar i = 0; i < NUM_BRT; i++) begin : g_brt_out
        assign brt_active[i*DW +: DW] = slot_act[BRT_BASE + i];
    end
    for (genvar i = 0; i < NUM_IMM; i++) begin : g_imm_out
        assign imm_active[i*DW +: DW] = slot_act[IMM_BASE + i];
    end
    assign shutter_active = slot_act[SHW_ADDR];
endmodule

// File: rtl/fsr_shadow_checker.sv
module fsr_shadow_checker #(
    parameter int DW      = 16,
    parameter int AW      = 5,
    parameter int NUM_GEO = 7,
    parameter int NUM_BRT = 4,
    parameter int NUM_IMM = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [AW-1:0]         wr_addr,
    input logic [DW-1:0]         wr_data,
    input logic                  frame_start,
    input logic                  restart,
    input logic                  sync_hold,
    input logic                  direct,
    input logic [NUM_GEO*DW-1:0] geo_active,
    input logic [NUM_BRT*DW-1:0] brt_active,
    input logic [DW-1:0]         shutter_active,
    input logic [NUM_IMM*DW-1:0] imm_active,
    input logic                  bubble
);
    localparam int IMM_BASE = NUM_GEO + NUM_BRT + 1;

    assert_imm_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(IMM_BASE)) |=> imm_active[DW-1:0] == $past(wr_data));

    assert_geo_waits_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !restart && !direct) |=> $stable(geo_active));

    assert_shutter_waits_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !restart && !direct) |=> $stable(shutter_active));

    assert_hold_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hold |=> $stable(brt_active));

    assert_bubble_on_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bubble) |-> $past(frame_start));

    assert_restart_clears_bubble_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !bubble);
endmodule

bind fsr_shadow_top fsr_shadow_checker #(
    .DW(DW), .AW(AW), .NUM_GEO(NUM_GEO), .NUM_BRT(NUM_BRT), .NUM_IMM(NUM_IMM)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .wr_data        (wr_data),
    .frame_start    (frame_start),
    .restart        (restart),
    .sync_hold      (sync_hold),
    .direct         (direct),
    .geo_active     (geo_active),
    .brt_active     (brt_active),
    .shutter_active (shutter_active),
    .imm_active     (imm_active),
    .bubble         (bubble)
);

// File: tb/fsr_shadow_top_test.sv
module fsr_shadow_top_test;
    localparam int DW = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [4:0]   wr_addr = '0;
    logic [15:0]  wr_data = '0;
    logic         frame_start = 1'b0;
    logic         frame_valid = 1'b0;
    logic         trigger = 1'b0;
    logic         snapshot_mode = 1'b0;
    logic         sync_hold = 1'b0;
    logic         restart = 1'b0;
    logic [111:0] geo_active;
    logic [63:0]  brt_active;
    logic [15:0]  shutter_active;
    logic [31:0]  imm_active;
    logic         bubble;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fsr_shadow_top uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_start(frame_start), .frame_valid(frame_valid), .trigger(trigger),
        .snapshot_mode(snapshot_mode), .sync_hold(sync_hold), .restart(restart),
        .geo_active(geo_active), .brt_active(brt_active), .shutter_active(shutter_active),
        .imm_active(imm_active), .bubble(bubble)
    );

    function automatic logic [15:0] geo(input int i);
        return geo_active[i*DW +: DW];
    endfunction
    function automatic logic [15:0] brt(input int i);
        return brt_active[i*DW +: DW];
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk16(input string req, input logic [15:0] act, input logic [15:0] exp);
        check(act == exp, req, 128'(act), 128'(exp));
    endtask

    task automatic write(input logic [4:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_fs();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic pulse_restart();
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    task automatic pulse_trig();
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
    endtask

    task automatic t_reset();
        check(geo_active == '0 && brt_active == '0 && shutter_active == '0 && imm_active == '0,
              "R1 active zero", 128'(geo_active), 128'(0));
        check(bubble == 1'b0, "R1 bubble low", 128'(bubble), 128'(0));
    endtask

    task automatic t_immediate();
        logic [111:0] g0;
        logic [63:0]  b0;
        logic [31:0]  i0;
        write(5'd12, 16'hA5A5);
        chk16("R2 plain field next cycle", imm_active[15:0], 16'hA5A5);
        write(5'd13, 16'h0F0F);
        chk16("R2 second plain field", imm_active[31:16], 16'h0F0F);
        g0 = geo_active; b0 = brt_active; i0 = imm_active;
        write(5'd14, 16'hFFFF);
        pulse_fs();
        pulse_fs();
        check(geo_active == g0 && brt_active == b0 && imm_active == i0 && shutter_active == 16'h0,
              "R2 out-of-range ignored", 128'(imm_active), 128'(i0));
    endtask

    task automatic t_frame_commit();
        frame_valid = 1'b1;
        write(5'd0, 16'h0100);
        write(5'd7, 16'h0033);
        chk16("R3 geometry held before frame start", geo(0), 16'h0);
        chk16("R3 brightness held before frame start", brt(0), 16'h0);
        pulse_fs();
        chk16("R3 geometry committed", geo(0), 16'h0100);
        chk16("R3 brightness committed", brt(0), 16'h0033);
        check(bubble == 1'b1, "R9 bubble after geometry write", 128'(bubble), 128'(1));
        pulse_fs();
        check(bubble == 1'b0, "R9 bubble lasts one frame", 128'(bubble), 128'(0));
        write(5'd0, 16'h0100);
        pulse_fs();
        check(bubble == 1'b1, "R9 bubble on unchanged value", 128'(bubble), 128'(1));
        pulse_fs();
    endtask

    task automatic t_last_wins();
        write(5'd1, 16'h0001);
        write(5'd1, 16'h0002);
        pulse_fs();
        chk16("R11 last write committed", geo(1), 16'h0002);
        pulse_fs();
    endtask

    task automatic t_shutter();
        write(5'd11, 16'h0050);
        pulse_fs();
        chk16("R4 shutter unchanged after one frame", shutter_active, 16'h0);
        check(bubble == 1'b0, "R9 no bubble from shutter write", 128'(bubble), 128'(0));
        pulse_fs();
        chk16("R4 shutter after two frames", shutter_active, 16'h0050);
    endtask

    task automatic t_hold();
        sync_hold = 1'b1;
        write(5'd8, 16'h0077);
        write(5'd2, 16'h0022);
        pulse_fs();
        chk16("R5 brightness held", brt(1), 16'h0);
        chk16("R5 geometry not held", geo(2), 16'h0022);
        pulse_fs();
        chk16("R5 brightness still held", brt(1), 16'h0);
        sync_hold = 1'b0;
        @(negedge clk);
        chk16("R5 release waits for frame", brt(1), 16'h0);
        pulse_fs();
        chk16("R5 brightness released", brt(1), 16'h0077);
        pulse_fs();
    endtask

    task automatic t_restart();
        sync_hold = 1'b1;
        write(5'd9, 16'h0099);
        write(5'd3, 16'h0033);
        write(5'd11, 16'h0011);
        write(5'd11, 16'h0012);
        pulse_restart();
        chk16("R6 geometry on restart", geo(3), 16'h0033);
        chk16("R6 latest shutter on restart", shutter_active, 16'h0012);
        chk16("R6 held brightness kept", brt(2), 16'h0);
        check(bubble == 1'b0, "R10 restart clears bubble", 128'(bubble), 128'(0));
        sync_hold = 1'b0;
        pulse_fs();
        check(bubble == 1'b0, "R10 pending bubble discarded", 128'(bubble), 128'(0));
        chk16("R6 brightness after hold release", brt(2), 16'h0099);
    endtask

    task automatic t_snapshot();
        snapshot_mode = 1'b1;
        frame_valid = 1'b1;
        @(negedge clk);
        frame_valid = 1'b0;
        @(negedge clk);
        write(5'd4, 16'h0044);
        chk16("R7 snapshot window immediate", geo(4), 16'h0044);
        write(5'd11, 16'h0066);
        chk16("R7 shutter immediate in window", shutter_active, 16'h0066);
        pulse_trig();
        write(5'd4, 16'h0045);
        chk16("R7 window closed by trigger", geo(4), 16'h0044);
        pulse_fs();
        chk16("R7 post-trigger write at frame", geo(4), 16'h0045);
        check(bubble == 1'b0, "R10 no bubble in snapshot", 128'(bubble), 128'(0));
    endtask

    task automatic t_trig_in_frame();
        frame_valid = 1'b1;
        @(negedge clk);
        pulse_trig();
        frame_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        write(5'd5, 16'h0055);
        chk16("R8 trigger in frame keeps frame rule", geo(5), 16'h0);
        pulse_fs();
        chk16("R8 committed at frame start", geo(5), 16'h0055);
        snapshot_mode = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_immediate();
        t_frame_commit();
        t_last_wins();
        t_shutter();
        t_hold();
        t_restart();
        t_snapshot();
        t_trig_in_frame();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule